// File: doc/BRIEF.md
# Interrupt Controller Command Port

This block is the byte-wide register front end of one eight-input interrupt controller. Software talks to it through two addresses. Address 0 takes the first setup word and all run-time commands. Address 1 takes the mask and the later setup words. The port decodes each write and turns it into held configuration levels and one-cycle action strobes for the priority core. The held levels are the mask, the vector base, the mode flags and the special-mask flag. The strobes clear in-service or request bits, load a new rotation offset, or reset the core.

The core evaluates priorities and reports its results back on dedicated inputs. These are the highest in-service input, the best deliverable input, and the raw request and in-service vectors. The port uses them for end-of-interrupt commands, for poll reads and for register readback. Every result (read data and strobes) is registered and appears in the cycle after the access strobe.

Top module: `icp_cmd_port`

## Requirements
- R1: After reset every output is zero. The setup sequence is idle, so the next address-1 write loads the mask. Reads return the request vector, and poll is disarmed.
- R2: A write to address 0 with bit 4 set gives a one-cycle `init_pulse` in the next cycle. It clears the mask, vector base, mode flags, rotate flag, special-mask flag and read select, and disarms poll. It records bit 0 as "fourth word wanted" and makes the next address-1 write the base word.
- R3: During setup, the base word drives `vbase_o` from its bits 7:3. The base word and the following third word never change `mask_o`. The mask changes only through a normal-state address-1 write or a setup start.
- R4: After the third word, setup ends when the fourth-word flag is 0. When the flag is 1, one more address-1 write sets `sfnm_o` from bit 4 and `aeoi_o` from bit 1 and then ends setup. After setup ends, an address-1 write loads `mask_o` with the full byte.
- R5: An address-0 write with bit 4 = 0 and bit 3 = 1 is a control word. If bit 1 is set, bit 0 picks what address-0 reads return: 1 for the in-service vector, 0 for the request vector. If bit 1 is clear, the choice is kept.
- R6: In a control word, bit 6 = 1 copies bit 5 into `spec_mask_o`. Bit 6 = 0 leaves `spec_mask_o` unchanged.
- R7: For an address-0 write with bits 4:3 = 00, bits 7:5 form a command code. Code 0 clears `rot_aeoi_o` and code 4 sets it.
- R8: Codes 1 and 5 strobe `isr_clr` with the one-hot bit of `top_isr_num` when `top_isr_vld` is high. Code 5 also strobes `ofs_set` with `ofs_val` = (`top_isr_num` + 1) mod 8. When `top_isr_vld` is low, neither code has any effect.
- R9: Code 3 clears in-service bit (data & 7). Code 6 strobes `ofs_set` with (data + 1) mod 8. Code 7 does both of these for input (data & 7). Code 2 does nothing. `ofs_val` reads 0 whenever `ofs_set` is low.
- R10: A read returns its value on `rdata` one cycle after `rd_en`. Address 1 returns the mask. Address 0 returns the selected vector. `rdata` holds its value between reads.
- R11: A read while poll is armed returns `best_num` and strobes the matching bit on both `irr_clr` and `isr_clr` if `best_vld` is high. If `best_vld` is low, it returns 7 with no strobe. Either way the read disarms poll. A control word with bit 2 set arms poll.
- R12: A read and a write in the same cycle both take effect. The read uses the state from before the write. Clear strobes from a poll read and from an EOI command are ORed together. A poll-arming write in the same cycle as a poll read leaves poll armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| addr | input | 1 | Register address bit |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| req_vec | input | 8 | Request vector from the core |
| isr_vec | input | 8 | In-service vector from the core |
| best_vld | input | 1 | Core has a deliverable input |
| best_num | input | 3 | Number of the best deliverable input |
| top_isr_vld | input | 1 | Some in-service bit is set |
| top_isr_num | input | 3 | Highest-priority in-service input |
| init_pulse | output | 1 | Core reset strobe on setup start |
| isr_clr | output | 8 | In-service clear strobes |
| irr_clr | output | 8 | Request clear strobes |
| ofs_set | output | 1 | Rotation offset load strobe |
| ofs_val | output | 3 | New rotation offset |
| mask_o | output | 8 | Interrupt mask |
| vbase_o | output | 5 | Vector base, upper five bits |
| aeoi_o | output | 1 | Automatic end-of-interrupt mode |
| sfnm_o | output | 1 | Special fully nested mode |
| rot_aeoi_o | output | 1 | Rotate on automatic EOI |
| spec_mask_o | output | 1 | Special mask mode |

## Verification
A poll read and an end-of-interrupt write can land in the same cycle, and both want the clear strobes. The bench arms poll and then, in one cycle, issues a read together with a specific EOI for a different input. It expects the in-service strobe to carry both bits and the request strobe to carry only the polled one. In a second collision, a write re-arms poll in the same cycle as a poll read. The bench judges this by the next read, which must again be a poll result. A reference model compares every output on every clock, and this is backed by a long mixed run with random concurrent reads and writes.

// File: rtl/icp_pkg.sv
package icp_pkg;
    localparam int NIN = 8;
    localparam int IW  = $clog2(NIN);
    localparam int DW  = 8;
    localparam int VBW = DW - IW;

    // bit positions of the address-0 word
    localparam int B_INIT = 4;
    localparam int B_CTRL = 3;
    localparam int B_POLL = 2;
    localparam int B_SELW = 1;
    localparam int B_SELV = 0;
    localparam int B_SMW  = 6;
    localparam int B_SMV  = 5;
    localparam int B_N4   = 0;
    // bit positions of the fourth setup word
    localparam int B_NEST = 4;
    localparam int B_AUTO = 1;

    typedef enum logic [1:0] {
        ST_NORM = 2'd0,
        ST_BASE = 2'd1,
        ST_W3   = 2'd2,
        ST_W4   = 2'd3
    } setup_e;

    typedef struct packed {
        logic           do_init;
        logic           need4_v;
        logic           poll_arm;
        logic           sel_we;
        logic           sel_v;
        logic           sm_we;
        logic           sm_v;
        logic           rot_we;
        logic           rot_v;
        logic [NIN-1:0] clr_vec;
        logic           ofs_we;
        logic [IW-1:0]  ofs_v;
        logic           mask_we;
        logic           vbase_we;
        logic           mode_we;
        setup_e         st_nx;
    } wr_act_t;

    typedef struct packed {
        logic           init_pulse;
        logic [NIN-1:0] isr_clr;
        logic [NIN-1:0] irr_clr;
        logic           ofs_set;
        logic [IW-1:0]  ofs_val;
        logic [DW-1:0]  mask;
        logic [VBW-1:0] vbase;
        logic           aeoi;
        logic           sfnm;
        logic           rot;
        logic           smask;
        logic           sel;
        logic           poll;
        logic           need4;
        setup_e         st;
        logic [DW-1:0]  rdata;
    } port_st_t;
endpackage

// File: rtl/icp_wr_decode.sv
module icp_wr_decode
    import icp_pkg::*;
(
    input  logic          wr_en,
    input  logic          addr,
    input  logic [DW-1:0] wdata,
    input  setup_e        st,
    input  logic          need4,
    input  logic          top_isr_vld,
    input  logic [IW-1:0] top_isr_num,
    output wr_act_t       act
);
    localparam logic [NIN-1:0] ONE = {{(NIN-1){1'b0}}, 1'b1};

    logic [2:0]    code;
    logic [IW-1:0] dsel;

    assign code = wdata[DW-1:DW-3];
    assign dsel = wdata[IW-1:0];

    always_comb begin
        act          = '0;
        act.st_nx    = st;
        if (wr_en && !addr) begin
            if (wdata[B_INIT]) begin
                act.do_init = 1'b1;
                act.need4_v = wdata[B_N4];
                act.st_nx   = ST_BASE;
            end else if (wdata[B_CTRL]) begin
                act.poll_arm = wdata[B_POLL];
                act.sel_we   = wdata[B_SELW];
                act.sel_v    = wdata[B_SELV];
                act.sm_we    = wdata[B_SMW];
                act.sm_v     = wdata[B_SMV];
            end else begin
                unique case (code)
                    3'd0, 3'd4: begin
                        act.rot_we = 1'b1;
                        act.rot_v  = code[2];
                    end
                    3'd1, 3'd5: begin
                        if (top_isr_vld) begin
                            act.clr_vec = ONE << top_isr_num;
                            act.ofs_we  = code[2];
                            act.ofs_v   = code[2] ? top_isr_num + 1'b1 : '0;
                        end
                    end
                    3'd3: act.clr_vec = ONE << dsel;
                    3'd6: begin
                        act.ofs_we = 1'b1;
                        act.ofs_v  = dsel + 1'b1;
                    end
                    3'd7: begin
                        act.clr_vec = ONE << dsel;
                        act.ofs_we  = 1'b1;
                        act.ofs_v   = dsel + 1'b1;
                    end
                    default: ;
                endcase
            end
        end else if (wr_en && addr) begin
            unique case (st)
                ST_NORM: act.mask_we = 1'b1;
                ST_BASE: begin
                    act.vbase_we = 1'b1;
                    act.st_nx    = ST_W3;
                end
                ST_W3:   act.st_nx = need4 ? ST_W4 : ST_NORM;
                ST_W4: begin
                    act.mode_we = 1'b1;
                    act.st_nx   = ST_NORM;
                end
                default: act.st_nx = ST_NORM;
            endcase
        end
    end
endmodule

// File: rtl/icp_rd_mux.sv
module icp_rd_mux
    import icp_pkg::*;
(
    input  logic           rd_en,
    input  logic           addr,
    input  logic           poll,
    input  logic           sel,
    input  logic [DW-1:0]  mask,
    input  logic [NIN-1:0] req_vec,
    input  logic [NIN-1:0] isr_vec,
    input  logic           best_vld,
    input  logic [IW-1:0]  best_num,
    output logic [DW-1:0]  rd_val,
    output logic [NIN-1:0] poll_clr
);
    localparam logic [NIN-1:0] ONE = {{(NIN-1){1'b0}}, 1'b1};
    localparam logic [DW-1:0]  NONE_CODE = {{(DW-IW){1'b0}}, {IW{1'b1}}};

    always_comb begin
        rd_val   = '0;
        poll_clr = '0;
        if (rd_en) begin
            if (poll) begin
                if (best_vld) begin
                    rd_val   = {{(DW-IW){1'b0}}, best_num};
                    poll_clr = ONE << best_num;
                end else begin
                    rd_val = NONE_CODE;
                end
            end else if (addr) begin
                rd_val = mask;
            end else begin
                rd_val = sel ? isr_vec : req_vec;
            end
        end
    end
endmodule

// File: rtl/icp_cmd_port.sv
module icp_cmd_port
    import icp_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic           rd_en,
    input  logic           addr,
    input  logic [DW-1:0]  wdata,
    output logic [DW-1:0]  rdata,
    input  logic [NIN-1:0] req_vec,
    input  logic [NIN-1:0] isr_vec,
    input  logic           best_vld,
    input  logic [IW-1:0]  best_num,
    input  logic           top_isr_vld,
    input  logic [IW-1:0]  top_isr_num,
    output logic           init_pulse,
    output logic [NIN-1:0] isr_clr,
    output logic [NIN-1:0] irr_clr,
    output logic           ofs_set,
    output logic [IW-1:0]  ofs_val,
    output logic [DW-1:0]  mask_o,
    output logic [VBW-1:0] vbase_o,
    output logic           aeoi_o,
    output logic           sfnm_o,
    output logic           rot_aeoi_o,
    output logic           spec_mask_o
);
    port_st_t       cur_q, nxt_d;
    wr_act_t        act;
    logic [DW-1:0]  rd_val;
    logic [NIN-1:0] poll_clr;

    icp_wr_decode u_dec (
        .wr_en       (wr_en),
        .addr        (addr),
        .wdata       (wdata),
        .st          (cur_q.st),
        .need4       (cur_q.need4),
        .top_isr_vld (top_isr_vld),
        .top_isr_num (top_isr_num),
        .act         (act)
    );

    icp_rd_mux u_rd (
        .rd_en    (rd_en),
        .addr     (addr),
        .poll     (cur_q.poll),
        .sel      (cur_q.sel),
        .mask     (cur_q.mask),
        .req_vec  (req_vec),
        .isr_vec  (isr_vec),
        .best_vld (best_vld),
        .best_num (best_num),
        .rd_val   (rd_val),
        .poll_clr (poll_clr)
    );

    always_comb begin
        nxt_d            = cur_q;
        nxt_d.init_pulse = act.do_init;
        nxt_d.isr_clr    = poll_clr | act.clr_vec;
        nxt_d.irr_clr    = poll_clr;
        nxt_d.ofs_set    = act.ofs_we;
        nxt_d.ofs_val    = act.ofs_we ? act.ofs_v : '0;
        nxt_d.st         = act.st_nx;
        if (rd_en) begin
            nxt_d.rdata = rd_val;
            if (cur_q.poll) nxt_d.poll = 1'b0;
        end
        if (act.do_init) begin
            nxt_d.mask  = '0;
            nxt_d.vbase = '0;
            nxt_d.aeoi  = 1'b0;
            nxt_d.sfnm  = 1'b0;
            nxt_d.rot   = 1'b0;
            nxt_d.smask = 1'b0;
            nxt_d.sel   = 1'b0;
            nxt_d.poll  = 1'b0;
            nxt_d.need4 = act.need4_v;
        end
        if (act.poll_arm) nxt_d.poll  = 1'b1;
        if (act.sel_we)   nxt_d.sel   = act.sel_v;
        if (act.sm_we)    nxt_d.smask = act.sm_v;
        if (act.rot_we)   nxt_d.rot   = act.rot_v;
        if (act.mask_we)  nxt_d.mask  = wdata;
        if (act.vbase_we) nxt_d.vbase = wdata[DW-1:IW];
        if (act.mode_we) begin
            nxt_d.sfnm = wdata[B_NEST];
            nxt_d.aeoi = wdata[B_AUTO];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q    <= '0;
            cur_q.st <= ST_NORM;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign rdata       = cur_q.rdata;
    assign init_pulse  = cur_q.init_pulse;
    assign isr_clr     = cur_q.isr_clr;
    assign irr_clr     = cur_q.irr_clr;
    assign ofs_set     = cur_q.ofs_set;
    assign ofs_val     = cur_q.ofs_val;
    assign mask_o      = cur_q.mask;
    assign vbase_o     = cur_q.vbase;
    assign aeoi_o      = cur_q.aeoi;
    assign sfnm_o      = cur_q.sfnm;
    assign rot_aeoi_o  = cur_q.rot;
    assign spec_mask_o = cur_q.smask;
endmodule

// File: rtl/icp_cmd_port_chk.sv
module icp_cmd_port_chk
    import icp_pkg::*;
(
    input logic           clk,
    input logic           rst_n,
    input logic           wr_en,
    input logic           rd_en,
    input logic           addr,
    input logic [DW-1:0]  wdata,
    input logic [DW-1:0]  rdata,
    input logic           top_isr_vld,
    input logic           init_pulse,
    input logic [NIN-1:0] isr_clr,
    input logic [NIN-1:0] irr_clr,
    input logic           ofs_set,
    input logic [IW-1:0]  ofs_val,
    input logic [DW-1:0]  mask_o
);
    AST_INIT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr && wdata[B_INIT]) |=> init_pulse); // R2

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mask_o)); // R3

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata)); // R10

    AST_ROT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr && wdata[7:3] == 5'b11000)
        |=> (ofs_set && ofs_val == 3'($past(wdata[2:0]) + 3'd1))); // R9

    AST_NOP_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr && wdata[7:3] == 5'b01000 && !rd_en)
        |=> (isr_clr == '0 && !ofs_set)); // R9

    AST_NSEOI_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr && wdata[7:3] == 5'b00100 && !top_isr_vld && !rd_en)
        |=> (isr_clr == '0)); // R8

    AST_POLL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irr_clr)); // R11

    AST_IRR_IN_ISR: assert property (@(posedge clk) disable iff (!rst_n)
        (irr_clr & ~isr_clr) == '0); // R11
endmodule

bind icp_cmd_port icp_cmd_port_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .addr        (addr),
    .wdata       (wdata),
    .rdata       (rdata),
    .top_isr_vld (top_isr_vld),
    .init_pulse  (init_pulse),
    .isr_clr     (isr_clr),
    .irr_clr     (irr_clr),
    .ofs_set     (ofs_set),
    .ofs_val     (ofs_val),
    .mask_o      (mask_o)
);

// File: tb/sim_icp_cmd_port.sv
`timescale 1ns/1ps
module sim_icp_cmd_port;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] req_vec = '0, isr_vec = '0;
    logic best_vld = 1'b0, top_isr_vld = 1'b0;
    logic [2:0] best_num = '0, top_isr_num = '0;
    logic [7:0] rdata, isr_clr, irr_clr, mask_o;
    logic init_pulse, ofs_set, aeoi_o, sfnm_o, rot_aeoi_o, spec_mask_o;
    logic [2:0] ofs_val;
    logic [4:0] vbase_o;

    always #2 clk = ~clk;

    icp_cmd_port u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .req_vec(req_vec), .isr_vec(isr_vec),
        .best_vld(best_vld), .best_num(best_num), .top_isr_vld(top_isr_vld),
        .top_isr_num(top_isr_num), .init_pulse(init_pulse), .isr_clr(isr_clr),
        .irr_clr(irr_clr), .ofs_set(ofs_set), .ofs_val(ofs_val), .mask_o(mask_o),
        .vbase_o(vbase_o), .aeoi_o(aeoi_o), .sfnm_o(sfnm_o),
        .rot_aeoi_o(rot_aeoi_o), .spec_mask_o(spec_mask_o)
    );

    // behavioural reference model
    logic [7:0] m_rd, m_isrc, m_irrc, m_mask;
    logic [4:0] m_vbase;
    logic [2:0] m_ofsv;
    logic m_init, m_ofs, m_aeoi, m_sfnm, m_rot, m_sm, m_sel, m_poll, m_need4;
    int m_st;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_rd = 0; m_isrc = 0; m_irrc = 0; m_mask = 0; m_vbase = 0; m_ofsv = 0;
            m_init = 0; m_ofs = 0; m_aeoi = 0; m_sfnm = 0; m_rot = 0; m_sm = 0;
            m_sel = 0; m_poll = 0; m_need4 = 0; m_st = 0;
        end else begin
            m_init = 0; m_isrc = 0; m_irrc = 0; m_ofs = 0; m_ofsv = 0;
            if (rd_en) begin
                if (m_poll) begin
                    if (best_vld) begin
                        m_rd = {5'd0, best_num};
                        m_isrc = 8'd1 << best_num;
                        m_irrc = 8'd1 << best_num;
                    end else m_rd = 8'd7;
                    m_poll = 0;
                end else if (addr) m_rd = m_mask;
                else m_rd = m_sel ? isr_vec : req_vec;
            end
            if (wr_en && !addr) begin
                if (wdata[4]) begin
                    m_init = 1; m_mask = 0; m_vbase = 0; m_aeoi = 0; m_sfnm = 0;
                    m_rot = 0; m_sm = 0; m_sel = 0; m_poll = 0;
                    m_need4 = wdata[0]; m_st = 1;
                end else if (wdata[3]) begin
                    if (wdata[2]) m_poll = 1;
                    if (wdata[1]) m_sel = wdata[0];
                    if (wdata[6]) m_sm = wdata[5];
                end else begin
                    case (wdata[7:5])
                        3'd0: m_rot = 0;
                        3'd4: m_rot = 1;
                        3'd1, 3'd5: if (top_isr_vld) begin
                            m_isrc = m_isrc | (8'd1 << top_isr_num);
                            if (wdata[7]) begin m_ofs = 1; m_ofsv = top_isr_num + 3'd1; end
                        end
                        3'd3: m_isrc = m_isrc | (8'd1 << wdata[2:0]);
                        3'd6: begin m_ofs = 1; m_ofsv = wdata[2:0] + 3'd1; end
                        3'd7: begin
                            m_isrc = m_isrc | (8'd1 << wdata[2:0]);
                            m_ofs = 1; m_ofsv = wdata[2:0] + 3'd1;
                        end
                        default: ;
                    endcase
                end
            end else if (wr_en && addr) begin
                case (m_st)
                    0: m_mask = wdata;
                    1: begin m_vbase = wdata[7:3]; m_st = 2; end
                    2: m_st = m_need4 ? 3 : 0;
                    default: begin m_sfnm = wdata[4]; m_aeoi = wdata[1]; m_st = 0; end
                endcase
            end
        end
    end

    int n_vec = 0, n_bad = 0, cycles = 0;
    string tag = "R1";
    logic chk_on = 1'b0;

    task automatic cmp(string what, logic [7:0] act, logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (chk_on) begin
            cmp("rdata", rdata, m_rd);
            cmp("init_pulse", {7'd0, init_pulse}, {7'd0, m_init});
            cmp("isr_clr", isr_clr, m_isrc);
            cmp("irr_clr", irr_clr, m_irrc);
            cmp("ofs_set", {7'd0, ofs_set}, {7'd0, m_ofs});
            cmp("ofs_val", {5'd0, ofs_val}, {5'd0, m_ofsv});
            cmp("mask_o", mask_o, m_mask);
            cmp("vbase_o", {3'd0, vbase_o}, {3'd0, m_vbase});
            cmp("modes", {4'd0, aeoi_o, sfnm_o, rot_aeoi_o, spec_mask_o},
                {4'd0, m_aeoi, m_sfnm, m_rot, m_sm});
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic cyc(logic w, logic wa, logic [7:0] wd, logic r, logic ra);
        @(posedge clk); #1;
        wr_en = w; addr = w ? wa : ra; wdata = wd; rd_en = r;
    endtask
    task automatic wr(logic wa, logic [7:0] wd); cyc(1, wa, wd, 0, 0); endtask
    task automatic rd(logic ra); cyc(0, 0, 8'h00, 1, ra); endtask
    task automatic idle(); cyc(0, 0, 8'h00, 0, 0); endtask

    initial begin
        @(posedge clk); #1 chk_on = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tag = "R1"; idle(); idle(); rd(1); rd(0); idle();
        // setup with fourth word
        tag = "R2"; wr(0, 8'h11); idle();
        tag = "R3"; wr(1, 8'h4B); wr(1, 8'hFF); idle();
        tag = "R4"; wr(1, 8'h12); wr(1, 8'hA5); rd(1); idle();
        // setup without fourth word, then mask load
        tag = "R2"; wr(0, 8'h10); tag = "R3"; wr(1, 8'hF8); wr(1, 8'h77);
        tag = "R4"; wr(1, 8'h3C); rd(1); idle();
        // read select
        tag = "R5"; req_vec = 8'h96; isr_vec = 8'h21;
        rd(0); wr(0, 8'h0B); rd(0); wr(0, 8'h09); rd(0); wr(0, 8'h0A); rd(0); idle();
        // special mask
        tag = "R6"; wr(0, 8'h68); idle(); wr(0, 8'h28); idle(); wr(0, 8'h48); idle();
        // rotate flag
        tag = "R7"; wr(0, 8'h80); idle(); wr(0, 8'h00); idle();
        // non-specific EOI
        tag = "R8"; top_isr_vld = 1; top_isr_num = 3'd5;
        wr(0, 8'h20); wr(0, 8'hA0); top_isr_num = 3'd7; wr(0, 8'hA0);
        top_isr_vld = 0; wr(0, 8'h20); wr(0, 8'hA0); idle();
        // specific EOI, set offset, both, no-op
        tag = "R9"; wr(0, 8'h63); wr(0, 8'hC7); wr(0, 8'hE4); wr(0, 8'h45); idle();
        // poll
        tag = "R11"; best_vld = 1; best_num = 3'd6; wr(0, 8'h0C); rd(1); rd(1);
        best_vld = 0; wr(0, 8'h0C); rd(0); rd(0); idle();
        // read latency and hold
        tag = "R10"; rd(1); idle(); idle(); rd(0); idle();
        // collisions
        tag = "R12"; best_vld = 1; best_num = 3'd6; wr(0, 8'h0C);
        cyc(1, 0, 8'h62, 1, 0);
        wr(0, 8'h0C); cyc(1, 0, 8'h0C, 1, 1); rd(1); rd(1);
        wr(1, 8'h5A); cyc(1, 1, 8'hC3, 1, 1); rd(1); idle();
        // mixed traffic
        for (int i = 0; i < 400; i++) begin
            req_vec = 8'($urandom); isr_vec = 8'($urandom);
            best_vld = 1'($urandom); best_num = 3'($urandom);
            top_isr_vld = 1'($urandom); top_isr_num = 3'($urandom);
            cyc(1'($urandom), 1'($urandom), 8'($urandom), 1'($urandom), 1'($urandom));
        end
        idle(); idle();
        @(negedge clk); #1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule